// File: doc/BRIEF.md
# Configurable Pad Cell with Input Capture and Output Register

This block models one user-configurable I/O cell of a programmable-logic fabric. Its behaviour is fixed by a small vector of static configuration bits. The pad-side receiver value reaches the core on two paths at once: unchanged, and through an input storage element. That element works either as an edge-triggered flip-flop or as a level-sensitive latch.

The input storage element is clocked from one of several shared input clock lines. The output side drives the pad data and its enable. The pad data comes either from an output flip-flop or straight from the core, and the data and the enable each have their own inversion. The output flip-flop is clocked from one of several shared output clock lines. Clock sense is not set per cell. Each shared line carries one polarity bit, and every cell on that line sees it.

Storage elements clear asynchronously while the chip reset is low or while the device is being configured. The physical tri-state buffer sits outside the cell: the cell hands it a data value and an enable. Whatever is on the pad, whether driven by this cell or by someone else, comes back on `pad_in`.

Top module: `cfg_io_cell`

## Requirements
- R1: `core_in_direct` equals `pad_in` at all times, in every mode, and is available at the same time as `core_in_reg`.
- R2: With `in_latch`=0 and the selected input line's polarity bit 0, `core_in_reg` takes the value of `pad_in` on each rising edge of the selected input line and holds it otherwise.
- R3: With `in_latch`=1 and polarity bit 0, `core_in_reg` follows `pad_in` while the selected input line is low and holds the last value while it is high.
- R4: A polarity bit of 1 on an input line turns the flip-flop into a falling-edge device and makes the latch transparent while that line is high; the bit belongs to the line, not the cell.
- R5: Field `in_line` picks which input clock line (index 0 or 1) drives the input storage; edges on the other line have no effect on `core_in_reg`.
- R6: With `out_registered`=1, `pad_out` shows the output flip-flop, which captures `core_out` on the rising effective edge of the selected output line; with `out_registered`=0, `pad_out` shows `core_out` directly.
- R7: `out_invert`=1 inverts the value on `pad_out` in both the registered and the direct mode.
- R8: `pad_oe` equals `core_oe` XOR `oe_invert`; when the enable is deasserted, an externally driven pad value still reaches the core through `pad_in`.
- R9: While `rst_n` is low, both storage elements are 0, so `core_in_reg`=0 and, in registered mode, `pad_out`=`out_invert`; the clear takes effect without a clock edge.
- R10: While `cfg_busy` is high, the cell behaves exactly as under R9, even with `rst_n` high, and clock edges capture nothing.
- R11: Field `out_line` picks the output clock line (index 0 or 1), and that line's output polarity bit set to 1 makes the output flip-flop capture on the falling edge.

Configuration word fields, from the most significant bit down: `in_latch`, `in_line`, `out_line`, `out_registered`, `out_invert`, `oe_invert`. The package struct `io_cell_cfg_t` defines this packing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| iclk_lines | input | 2 | Shared input clock/load lines |
| iclk_line_inv | input | 2 | Polarity bit per input line (1 = inverted sense) |
| oclk_lines | input | 2 | Shared output clock lines |
| oclk_line_inv | input | 2 | Polarity bit per output line (1 = falling edge) |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| cfg_busy | input | 1 | High while the device is being configured; holds the cell cleared |
| cfg_bits | input | 6 | Static configuration word (`io_cell_cfg_t`) |
| pad_in | input | 1 | Receiver value seen at the pad |
| pad_out | output | 1 | Data toward the pad driver |
| pad_oe | output | 1 | Enable for the pad driver |
| core_out | input | 1 | Output data from core logic |
| core_oe | input | 1 | Output enable from core logic |
| core_in_direct | output | 1 | Unregistered pad value to core |
| core_in_reg | output | 1 | Input storage element output to core |

## Verification
The bench runs a behavioural model that re-derives every effective clock from the line values and the polarity bits each cycle, and compares all four outputs on every clock. It goes after the following corner cases, each paired with the error it would expose:
- Data changing while the latch is open and then closing: a design that used an edge instead of a level would miss the update.
- Inverted polarity: a design that ignored it would capture on the wrong edge or open the latch in the wrong phase.
- Edges on the unselected line: a design that decoded the line field wrongly would capture on them.
- The four inversion combinations, with the enable dropped while an outside value sits on the pad, and a configuration-busy window with the chip reset high: a reset that looked only at `rst_n` would keep capturing during that window.

// File: rtl/io_cell_pkg.sv
package io_cell_pkg;

    localparam int N_LINES = 2;
    localparam int SEL_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1;

    typedef struct packed {
        logic             in_latch;
        logic [SEL_W-1:0] in_line;
        logic [SEL_W-1:0] out_line;
        logic             out_registered;
        logic             out_invert;
        logic             oe_invert;
    } io_cell_cfg_t;

    localparam int CFG_W = $bits(io_cell_cfg_t);

    function automatic logic line_level(input logic raw, input logic invert);
        return raw ^ invert;
    endfunction

endpackage

// File: rtl/io_clk_pick.sv
module io_clk_pick
    import io_cell_pkg::*;
(
    input  logic [N_LINES-1:0] lines,
    input  logic [N_LINES-1:0] line_inv,
    input  logic [SEL_W-1:0]   sel,
    output logic               eff_clk
);

    assign eff_clk = line_level(lines[sel], line_inv[sel]);

endmodule

// File: rtl/io_in_store.sv
module io_in_store (
    input  logic eff_clk,
    input  logic clr_n,
    input  logic latch_mode,
    input  logic d,
    output logic q
);

    logic ff_q;
    logic lat_q;
    logic armed;

    always_ff @(posedge eff_clk or negedge clr_n) begin
        if (!clr_n) ff_q <= 1'b0;
        else        ff_q <= d;
    end

    // level-sensitive element: open while the effective load level is low
    always_latch begin
        if (!clr_n)        lat_q <= 1'b0;
        else if (!eff_clk) lat_q <= d;
    end

    assign q = latch_mode ? lat_q : ff_q;

    // goes low on any clear since the last edge, so the edge check skips that window
    always_ff @(posedge eff_clk or negedge clr_n) begin
        if (!clr_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_ff_captures_R2: assert property (@(posedge eff_clk) disable iff (!clr_n)
        1'b1 |=> (!armed || ff_q == $past(d)));

    assert_latch_follows_R3: assert property (@(posedge eff_clk) disable iff (!clr_n)
        latch_mode |-> (q == d));

endmodule

// File: rtl/io_out_path.sv
module io_out_path (
    input  logic eff_clk,
    input  logic clr_n,
    input  logic registered,
    input  logic data_inv,
    input  logic en_inv,
    input  logic core_out,
    input  logic core_oe,
    output logic pad_out,
    output logic pad_oe
);

    logic oq;
    logic armed;

    always_ff @(posedge eff_clk or negedge clr_n) begin
        if (!clr_n) oq <= 1'b0;
        else        oq <= core_out;
    end

    assign pad_out = (registered ? oq : core_out) ^ data_inv;
    assign pad_oe  = core_oe ^ en_inv;

    always_ff @(posedge eff_clk or negedge clr_n) begin
        if (!clr_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_out_ff_captures_R11: assert property (@(posedge eff_clk) disable iff (!clr_n)
        1'b1 |=> (!armed || oq == $past(core_out)));

endmodule

// File: rtl/cfg_io_cell.sv
module cfg_io_cell
    import io_cell_pkg::*;
(
    input  logic [N_LINES-1:0] iclk_lines,
    input  logic [N_LINES-1:0] iclk_line_inv,
    input  logic [N_LINES-1:0] oclk_lines,
    input  logic [N_LINES-1:0] oclk_line_inv,
    input  logic               rst_n,
    input  logic               cfg_busy,
    input  logic [CFG_W-1:0]   cfg_bits,
    input  logic               pad_in,
    output logic               pad_out,
    output logic               pad_oe,
    input  logic               core_out,
    input  logic               core_oe,
    output logic               core_in_direct,
    output logic               core_in_reg
);

    io_cell_cfg_t cfg;
    logic         cell_clr_n;
    logic         in_clk;
    logic         out_clk;

    assign cfg        = io_cell_cfg_t'(cfg_bits);
    assign cell_clr_n = rst_n & ~cfg_busy;

    io_clk_pick u_in_pick (
        .lines    (iclk_lines),
        .line_inv (iclk_line_inv),
        .sel      (cfg.in_line),
        .eff_clk  (in_clk)
    );

    io_clk_pick u_out_pick (
        .lines    (oclk_lines),
        .line_inv (oclk_line_inv),
        .sel      (cfg.out_line),
        .eff_clk  (out_clk)
    );

    assign core_in_direct = pad_in;

    io_in_store u_in_store (
        .eff_clk    (in_clk),
        .clr_n      (cell_clr_n),
        .latch_mode (cfg.in_latch),
        .d          (pad_in),
        .q          (core_in_reg)
    );

    io_out_path u_out_path (
        .eff_clk    (out_clk),
        .clr_n      (cell_clr_n),
        .registered (cfg.out_registered),
        .data_inv   (cfg.out_invert),
        .en_inv     (cfg.oe_invert),
        .core_out   (core_out),
        .core_oe    (core_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    assert_busy_clears_in_R10: assert property (@(posedge in_clk) disable iff (!rst_n)
        cfg_busy |-> (core_in_reg == 1'b0));

    assert_busy_clears_out_R10: assert property (@(posedge out_clk) disable iff (!rst_n)
        (cfg_busy && cfg.out_registered) |-> (pad_out == cfg.out_invert));

endmodule

// File: tb/tb_cfg_io_cell.sv
module tb_cfg_io_cell;
    import io_cell_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [1:0]   il = 2'b00, ilinv = 2'b00, ol = 2'b00, olinv = 2'b00;
    logic         rst_n = 1'b0, busy = 1'b0;
    io_cell_cfg_t cfg = '0;
    logic         pad_in = 1'b0, core_out = 1'b0, core_oe = 1'b0;
    logic         pad_out, pad_oe, core_in_direct, core_in_reg;

    cfg_io_cell dut (
        .iclk_lines(il), .iclk_line_inv(ilinv), .oclk_lines(ol), .oclk_line_inv(olinv),
        .rst_n(rst_n), .cfg_busy(busy), .cfg_bits(cfg),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .core_out(core_out), .core_oe(core_oe),
        .core_in_direct(core_in_direct), .core_in_reg(core_in_reg)
    );

    int checks = 0, failures = 0;
    bit done = 0;
    bit m_ff = 0, m_lat = 0, m_oq = 0;
    string in_tag = "R2", out_tag = "R6";

    function automatic bit eff(logic [1:0] l, logic [1:0] inv, int s);
        return l[s] ^ inv[s];
    endfunction

    task automatic chk(string tag, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got=%b exp=%b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // one bench clock: data first, then clock lines, then compare
    task automatic step(logic [1:0] nil, logic [1:0] nol, logic p, logic co, logic coe,
                        logic nr, logic nb);
        bit pi, po, ni, no, clr;
        @(posedge clk);
        pi = eff(il, ilinv, int'(cfg.in_line));
        po = eff(ol, olinv, int'(cfg.out_line));
        #1;
        pad_in = p; core_out = co; core_oe = coe; rst_n = nr; busy = nb;
        clr = !nr || nb;
        if (clr) begin m_ff = 0; m_lat = 0; m_oq = 0; end
        else if (!pi) m_lat = p;
        #1;
        il = nil; ol = nol;
        ni = eff(il, ilinv, int'(cfg.in_line));
        no = eff(ol, olinv, int'(cfg.out_line));
        if (!clr) begin
            if (!pi && ni) m_ff = p;
            if (!ni) m_lat = p;
            if (!po && no) m_oq = co;
        end
        #2;
        begin
            string rt;
            rt = !nr ? "R9" : (nb ? "R10" : in_tag);
            chk("R1", "core_in_direct", core_in_direct, p);
            chk(rt, "core_in_reg", core_in_reg, cfg.in_latch ? m_lat : m_ff);
            chk((!nr) ? "R9" : (nb ? "R10" : out_tag), "pad_out", pad_out,
                (cfg.out_registered ? m_oq : co) ^ cfg.out_invert);
            chk("R8", "pad_oe", pad_oe, coe ^ cfg.oe_invert);
        end
    endtask

    task automatic reconfig(io_cell_cfg_t c, logic [1:0] ipol, logic [1:0] opol);
        step(il, ol, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        cfg = c; ilinv = ipol; olinv = opol;
        step(il, ol, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    // toggles the chosen line each step; other line toggles at half rate
    task automatic run(int n, int isel, int osel);
        for (int i = 0; i < n; i++) begin
            logic [1:0] a, b;
            a = isel ? {i[0], i[1]} : {i[1], i[0]};
            b = osel ? {i[0], i[1]} : {i[1], i[0]};
            step(a, b, 1'($urandom), 1'($urandom), 1'($urandom), 1'b1, 1'b0);
        end
    endtask

    initial begin
        io_cell_cfg_t c;
        // R9: reset state and async clear
        in_tag = "R9"; out_tag = "R9";
        c = '0; c.out_registered = 1'b1; c.out_invert = 1'b1;
        cfg = c;
        for (int i = 0; i < 4; i++)
            step({1'b0, i[0]}, {1'b0, i[0]}, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

        // R2 + R6: flip-flop, line 0, registered output
        in_tag = "R2"; out_tag = "R6";
        c = '0; c.out_registered = 1'b1;
        reconfig(c, 2'b00, 2'b00);
        run(24, 0, 0);
        // R9: reset drops mid-run, no clock edge needed
        step(il, ol, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        step(il, ol, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);

        // R3: latch, non-inverted
        in_tag = "R3"; c.in_latch = 1'b1;
        reconfig(c, 2'b00, 2'b00);
        run(24, 0, 0);
        step(2'b00, ol, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        step(2'b00, ol, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        step(2'b01, ol, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        step(2'b01, ol, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

        // R4: inverted input polarity, latch then flip-flop
        in_tag = "R4";
        reconfig(c, 2'b01, 2'b00);
        run(24, 0, 0);
        c.in_latch = 1'b0;
        reconfig(c, 2'b01, 2'b00);
        run(24, 0, 0);

        // R5: line 1 selected, line 0 edges must not capture
        in_tag = "R5"; c.in_line = 1'b1;
        reconfig(c, 2'b00, 2'b00);
        run(32, 1, 0);
        for (int i = 0; i < 6; i++)
            step({il[1], i[0]}, ol, 1'(~core_in_reg), 1'b0, 1'b0, 1'b1, 1'b0);

        // R7 + R8: direct and registered output, all inversion combinations
        in_tag = "R2";
        for (int k = 0; k < 8; k++) begin
            c = '0;
            c.out_registered = k[2]; c.out_invert = k[1]; c.oe_invert = k[0];
            out_tag = k[1] ? "R7" : "R6";
            reconfig(c, 2'b00, 2'b00);
            run(8, 0, 0);
        end

        // R11: output line 1 with falling-edge polarity
        out_tag = "R11";
        c = '0; c.out_registered = 1'b1; c.out_line = 1'b1;
        reconfig(c, 2'b00, 2'b10);
        run(24, 0, 1);

        // R10: configuration busy with rst_n high
        in_tag = "R10"; out_tag = "R10";
        for (int i = 0; i < 6; i++)
            step({1'b0, i[0]}, {i[0], 1'b0}, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        in_tag = "R2"; out_tag = "R11";
        run(8, 0, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog run did not finish got=hang exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule